// File: doc/BRIEF.md
# Tape Controller Command and Status Register Interface

This block is the programmed-I/O face of a tape controller. The processor talks to it through I/O instructions. Each instruction appears for one clock as a 12-bit instruction code with a valid strobe, together with the current accumulator word. The block holds two things. The first is a command word that selects a transport, sets the direction, the go/stop control, the mode and the function, and enables the interrupt. The second is a status word made of five sticky error flags, a summary error bit, a completion flag and a 3-bit memory field. The command fields drive the tape logic directly. The tape logic reports errors and completion back through one-cycle event pulses.

An instruction can return a word to OR onto the accumulator, ask for the accumulator to be cleared, or ask the processor to skip its next instruction. All three responses are combinational in the instruction cycle. State changes take effect at the clock edge that ends that cycle. Loading the command word XORs the accumulator into it rather than overwriting it. The same load can clear the error flags and the completion flag.

Bit 0 is the most significant bit of every 12-bit word. Accumulator bit k is `ac_in[11-k]`.

Top module: `tape_ctl_regs`

## Requirements
- R1: After a synchronous reset the following are all zero: the command word, every error flag, the completion flag and the memory field. As a result `unit_sel`, `dir_rev`, `go`, `cont_mode`, `func`, `mem_field` and `irq` are all 0.
- R2: Code 6764 (octal) XORs accumulator bits 0-9 (`ac_in[11:2]`) into command bits 0-9, and `ac_clear` is 1 in that cycle.
- R3: During code 6764, accumulator bit 10 (`ac_in[1]`) = 0 clears all five error flags, and accumulator bit 11 (`ac_in[0]`) = 0 clears the completion flag. A 1 leaves the matching flags unchanged.
- R4: Code 6762 sets the command word to zero and leaves every flag and the memory field unchanged.
- R5: Code 6761 returns the command word on `ac_out` as {bits 0-9, 2'b00}.
- R6: Code 6772 returns the status word on `ac_out`. From bit 0 to bit 11 it is: summary error, mark-track error, end-of-tape error, select error, parity error, timing error, memory field (3 bits), two zero bits, completion flag.
- R7: Code 6774 loads the memory field from accumulator bits 6-8 (`ac_in[5:3]`) and sets `ac_clear` to 1. It leaves the error flags and the completion flag unchanged.
- R8: Code 6771 sets `skip` to 1 in that cycle when any error flag or the completion flag is set, and to 0 otherwise.
- R9: A code 6764 that leaves function code 111 in command bits 6-8 sets the select error flag.
- R10: The event inputs set their flags (mark-track, end-of-tape, parity, timing, completion). Every flag stays set until it is cleared explicitly. The summary bit is the OR of the five error flags. An event set in the same cycle as a clear wins.
- R11: `irq` is command bit 9 ANDed with the OR of the summary error and the completion flag.
- R12: The outputs follow command fields bits 0-2 → `unit_sel` (000 also addresses unit 8), bit 3 → `dir_rev` (1 = reverse), bit 4 → `go`, bit 5 → `cont_mode`, and bits 6-8 → `func`. The function codes are 000 move, 001 search, 010 read data, 011 read all, 100 write data, 101 write all and 110 write timing.
- R13: When `iot_valid` is 0, or the code is none of the six codes, nothing changes. In those cycles `ac_out` is 0, `ac_clear` is 0 and `skip` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iot_valid | input | 1 | Instruction strobe, one cycle per instruction |
| iot_code | input | 12 | Instruction code |
| ac_in | input | 12 | Accumulator word |
| evt_mark | input | 1 | Mark-track error event |
| evt_eot | input | 1 | End-of-tape error event |
| evt_par | input | 1 | Parity error event |
| evt_tim | input | 1 | Timing error event |
| evt_done | input | 1 | Completion event |
| ac_out | output | 12 | Word to OR onto the accumulator |
| ac_clear | output | 1 | Clear-accumulator strobe |
| skip | output | 1 | Skip strobe |
| irq | output | 1 | Interrupt request |
| unit_sel | output | 3 | Transport unit |
| dir_rev | output | 1 | Reverse direction |
| go | output | 1 | Tape motion on |
| cont_mode | output | 1 | Continuous mode |
| func | output | 3 | Function code |
| mem_field | output | 3 | Memory field |

## Verification
The bench targets the XOR load. It sweeps all 1024 values of the ten loaded bits through one running command word. A design that overwrote the register instead of XORing would lose the earlier state, and the read-back would show it. It crosses every combination of the five events with all four settings of the two keep/clear bits. This exposes a design with the keep/clear polarity swapped, or one that drops an event arriving in the same cycle as a clear. It also sweeps every memory-field value, and every unused code in the instruction group, including a load code presented with the strobe low. A decoder that matched too loosely would then change state or raise a strobe on a code it should ignore.

// File: rtl/tape_ctl_pkg.sv
package tape_ctl_pkg;
    localparam int WORD_W  = 12;
    localparam int UNIT_W  = 3;
    localparam int FUNC_W  = 3;
    localparam int MF_W    = 3;
    localparam int NERR    = 5;
    localparam int CTRL_W  = 2;                 // accumulator keep/clear bits
    localparam int CMD_W   = WORD_W - CTRL_W;   // stored command bits
    localparam int MF_LSB  = 3;                 // accumulator bits 6-8 position

    // error vector index, MSB first as read out
    localparam int E_MARK = 4;
    localparam int E_EOT  = 3;
    localparam int E_SEL  = 2;
    localparam int E_PAR  = 1;
    localparam int E_TIM  = 0;

    localparam logic [WORD_W-1:0] CODE_RDA  = 12'o6761;
    localparam logic [WORD_W-1:0] CODE_CLRA = 12'o6762;
    localparam logic [WORD_W-1:0] CODE_LDA  = 12'o6764;
    localparam logic [WORD_W-1:0] CODE_SKIP = 12'o6771;
    localparam logic [WORD_W-1:0] CODE_RDB  = 12'o6772;
    localparam logic [WORD_W-1:0] CODE_LDMF = 12'o6774;

    typedef enum logic [FUNC_W-1:0] {
        FN_MOVE, FN_SEARCH, FN_RD_DATA, FN_RD_ALL,
        FN_WR_DATA, FN_WR_ALL, FN_WR_TIMING, FN_ILLEGAL
    } fn_e;

    typedef enum logic [2:0] {
        OP_NONE, OP_RDA, OP_CLRA, OP_LDA, OP_SKIP, OP_RDB, OP_LDMF
    } op_e;

    // first member is bit 0 (most significant)
    typedef struct packed {
        logic [UNIT_W-1:0] unit;
        logic              rev;
        logic              go;
        logic              cont;
        fn_e               func;
        logic              ie;
        logic [CTRL_W-1:0] rsvd;
    } cmd_t;

    typedef struct packed {
        logic              sum;
        logic [NERR-1:0]   err;
        logic [MF_W-1:0]   mf;
        logic [1:0]        rsvd;
        logic              done;
    } statb_t;

    function automatic logic keep_bit(input logic [WORD_W-1:0] ac, input int acbit);
        return ac[WORD_W-1-acbit];
    endfunction
endpackage

// File: rtl/tape_iot_decode.sv
module tape_iot_decode
    import tape_ctl_pkg::*;
(
    input  logic              iot_valid,
    input  logic [WORD_W-1:0] iot_code,
    output op_e               op
);
    always_comb begin
        op = OP_NONE;
        if (iot_valid) begin
            unique case (iot_code)
                CODE_RDA:  op = OP_RDA;
                CODE_CLRA: op = OP_CLRA;
                CODE_LDA:  op = OP_LDA;
                CODE_SKIP: op = OP_SKIP;
                CODE_RDB:  op = OP_RDB;
                CODE_LDMF: op = OP_LDMF;
                default:   op = OP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/tape_cmd_reg.sv
module tape_cmd_reg
    import tape_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  op_e               op,
    input  logic [WORD_W-1:0] ac_in,
    output cmd_t              cmd_q,
    output logic              sel_set
);
    cmd_t cmd_n;

    always_comb begin
        cmd_n = cmd_q;
        unique case (op)
            OP_CLRA: cmd_n = '0;
            OP_LDA:  cmd_n = cmd_t'({cmd_q[WORD_W-1:CTRL_W] ^ ac_in[WORD_W-1:CTRL_W],
                                     {CTRL_W{1'b0}}});
            default: cmd_n = cmd_q;
        endcase
    end

    // a load that leaves the illegal function in place flags a select error
    assign sel_set = (op == OP_LDA) && (cmd_n.func == FN_ILLEGAL);

    always_ff @(posedge clk) begin
        if (rst) cmd_q <= '0;
        else     cmd_q <= cmd_n;
    end
endmodule

// File: rtl/tape_status_flags.sv
module tape_status_flags
    import tape_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  op_e               op,
    input  logic [WORD_W-1:0] ac_in,
    input  logic [NERR-1:0]   err_set,
    input  logic              done_set,
    output logic [NERR-1:0]   err_q,
    output logic              done_q,
    output logic [MF_W-1:0]   mf_q
);
    localparam int AC_KEEP_ERR  = 10;
    localparam int AC_KEEP_DONE = 11;

    logic keep_err, keep_done;

    assign keep_err  = !(op == OP_LDA && !keep_bit(ac_in, AC_KEEP_ERR));
    assign keep_done = !(op == OP_LDA && !keep_bit(ac_in, AC_KEEP_DONE));

    for (genvar g = 0; g < NERR; g++) begin : g_err
        logic flag_q;
        always_ff @(posedge clk) begin
            if (rst) flag_q <= 1'b0;
            else     flag_q <= (flag_q & keep_err) | err_set[g];
        end
        assign err_q[g] = flag_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            mf_q   <= '0;
        end else begin
            done_q <= (done_q & keep_done) | done_set;
            if (op == OP_LDMF) mf_q <= ac_in[MF_LSB +: MF_W];
        end
    end
endmodule

// File: rtl/tape_ctl_regs.sv
module tape_ctl_regs
    import tape_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              iot_valid,
    input  logic [WORD_W-1:0] iot_code,
    input  logic [WORD_W-1:0] ac_in,
    input  logic              evt_mark,
    input  logic              evt_eot,
    input  logic              evt_par,
    input  logic              evt_tim,
    input  logic              evt_done,
    output logic [WORD_W-1:0] ac_out,
    output logic              ac_clear,
    output logic              skip,
    output logic              irq,
    output logic [UNIT_W-1:0] unit_sel,
    output logic              dir_rev,
    output logic              go,
    output logic              cont_mode,
    output logic [FUNC_W-1:0] func,
    output logic [MF_W-1:0]   mem_field
);
    op_e             op;
    cmd_t            cmd_q;
    logic            sel_set;
    logic [NERR-1:0] err_set;
    logic [NERR-1:0] err_q;
    logic            done_q;
    logic [MF_W-1:0] mf_q;
    logic            any_flag;
    statb_t          statb;

    tape_iot_decode u_dec (
        .iot_valid (iot_valid),
        .iot_code  (iot_code),
        .op        (op)
    );

    tape_cmd_reg u_cmd (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .ac_in   (ac_in),
        .cmd_q   (cmd_q),
        .sel_set (sel_set)
    );

    always_comb begin
        err_set         = '0;
        err_set[E_MARK] = evt_mark;
        err_set[E_EOT]  = evt_eot;
        err_set[E_SEL]  = sel_set;
        err_set[E_PAR]  = evt_par;
        err_set[E_TIM]  = evt_tim;
    end

    tape_status_flags u_flg (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .ac_in    (ac_in),
        .err_set  (err_set),
        .done_set (evt_done),
        .err_q    (err_q),
        .done_q   (done_q),
        .mf_q     (mf_q)
    );

    assign any_flag = (|err_q) | done_q;

    always_comb begin
        statb      = '0;
        statb.sum  = |err_q;
        statb.err  = err_q;
        statb.mf   = mf_q;
        statb.done = done_q;
    end

    always_comb begin
        unique case (op)
            OP_RDA:  ac_out = cmd_q;
            OP_RDB:  ac_out = statb;
            default: ac_out = '0;
        endcase
    end

    assign ac_clear  = (op == OP_LDA) || (op == OP_LDMF);
    assign skip      = (op == OP_SKIP) && any_flag;
    assign irq       = cmd_q.ie && any_flag;
    assign unit_sel  = cmd_q.unit;
    assign dir_rev   = cmd_q.rev;
    assign go        = cmd_q.go;
    assign cont_mode = cmd_q.cont;
    assign func      = cmd_q.func;
    assign mem_field = mf_q;
endmodule

// File: rtl/tape_ctl_regs_chk.sv
module tape_ctl_regs_chk
    import tape_ctl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              iot_valid,
    input logic [WORD_W-1:0] iot_code,
    input logic [WORD_W-1:0] ac_in,
    input logic              evt_mark,
    input logic              evt_eot,
    input logic              evt_par,
    input logic              evt_tim,
    input logic              evt_done,
    input logic [WORD_W-1:0] ac_out,
    input logic              ac_clear,
    input logic              skip,
    input logic              irq,
    input logic [UNIT_W-1:0] unit_sel,
    input logic              dir_rev,
    input logic              go,
    input logic              cont_mode,
    input logic [FUNC_W-1:0] func,
    input logic [MF_W-1:0]   mem_field,
    input logic [NERR-1:0]   err_q,
    input logic              done_q
);
    logic no_err_evt;
    assign no_err_evt = !evt_mark && !evt_eot && !evt_par && !evt_tim;

    assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (err_q == '0 && !done_q && unit_sel == '0 && func == '0
                        && !go && !dir_rev && !cont_mode && mem_field == '0 && !irq));

    assert_xor_R2: assert property (@(posedge clk) disable iff (rst)
        (iot_valid && iot_code == CODE_LDA) |=>
        ({unit_sel, dir_rev, go, cont_mode, func} ==
         $past({unit_sel, dir_rev, go, cont_mode, func} ^ ac_in[WORD_W-1:3])));

    assert_errclr_R3: assert property (@(posedge clk) disable iff (rst)
        (iot_valid && iot_code == CODE_LDA && !ac_in[1] && no_err_evt
         && ((func ^ ac_in[5:3]) != 3'b111)) |=> (err_q == '0));

    assert_clra_R4: assert property (@(posedge clk) disable iff (rst)
        (iot_valid && iot_code == CODE_CLRA && no_err_evt && !evt_done) |=>
        (unit_sel == '0 && func == '0 && !go && !dir_rev && !cont_mode
         && $stable(err_q) && $stable(done_q) && $stable(mem_field)));

    assert_mf_R7: assert property (@(posedge clk) disable iff (rst)
        (iot_valid && iot_code == CODE_LDMF && no_err_evt) |=>
        (mem_field == $past(ac_in[5:3]) && $stable(err_q)));

    assert_skip_R8: assert property (@(posedge clk) disable iff (rst)
        skip |-> (iot_valid && iot_code == CODE_SKIP && (err_q != '0 || done_q)));

    assert_sel_R9: assert property (@(posedge clk) disable iff (rst)
        (iot_valid && iot_code == CODE_LDA && ((func ^ ac_in[5:3]) == 3'b111))
        |=> err_q[E_SEL]);

    assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        !(iot_valid && iot_code == CODE_LDA && !ac_in[1]) |=>
        ((err_q & $past(err_q)) == $past(err_q)));

    assert_irq_R11: assert property (@(posedge clk) disable iff (rst)
        irq |-> (err_q != '0 || done_q));

    assert_idle_R13: assert property (@(posedge clk) disable iff (rst)
        !iot_valid |-> (ac_out == '0 && !ac_clear && !skip));
endmodule

bind tape_ctl_regs tape_ctl_regs_chk u_chk (.*);

// File: tb/sim_tape_ctl_regs.sv
module sim_tape_ctl_regs;
    import tape_ctl_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        iot_valid = 1'b0;
    logic [11:0] iot_code = '0;
    logic [11:0] ac_in = '0;
    logic [4:0]  ev = '0;   // [4] mark [3] eot [2] par [1] tim [0] done
    logic [11:0] ac_out;
    logic        ac_clear, skip, irq, dir_rev, go, cont_mode;
    logic [2:0]  unit_sel, func, mem_field;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // model state: command bits 0-9, errors {mark,eot,sel,par,tim}
    logic [9:0] mcmd = '0;
    logic [4:0] merr = '0;
    logic       mdone = 1'b0;
    logic [2:0] mmf = '0;

    always #2.5 clk = ~clk;

    tape_ctl_regs u0 (
        .clk(clk), .rst(rst), .iot_valid(iot_valid), .iot_code(iot_code), .ac_in(ac_in),
        .evt_mark(ev[4]), .evt_eot(ev[3]), .evt_par(ev[2]), .evt_tim(ev[1]), .evt_done(ev[0]),
        .ac_out(ac_out), .ac_clear(ac_clear), .skip(skip), .irq(irq),
        .unit_sel(unit_sel), .dir_rev(dir_rev), .go(go), .cont_mode(cont_mode),
        .func(func), .mem_field(mem_field)
    );

    task automatic chk(input bit ok, input string tag, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0o expected %0o", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] exp_b();
        return {|merr, merr, mmf, 2'b00, mdone};
    endfunction

    task automatic check_static(input string tag);
        chk({unit_sel, dir_rev, go, cont_mode, func} == mcmd[9:1], {tag, " R12"},
            {3'b0, unit_sel, dir_rev, go, cont_mode, func}, {3'b0, mcmd[9:1]});
        chk(mem_field == mmf, {tag, " R7 mf"}, {9'b0, mem_field}, {9'b0, mmf});
        chk(irq == (mcmd[0] & ((|merr) | mdone)), {tag, " R11"}, {11'b0, irq},
            {11'b0, mcmd[0] & ((|merr) | mdone)});
    endtask

    task automatic model_step(input bit vld, input logic [11:0] code, input logic [11:0] ac,
                              input logic [4:0] e);
        logic       ld;
        logic [9:0] nc;
        logic       sset;
        ld = vld && code == CODE_LDA;
        nc = mcmd;
        if (vld && code == CODE_CLRA) nc = '0;
        if (ld) nc = mcmd ^ ac[11:2];
        sset = ld && (nc[3:1] == 3'b111);
        merr = ((ld && !ac[1]) ? 5'b0 : merr) | {e[4], e[3], sset, e[2], e[1]};
        mdone = ((ld && !ac[0]) ? 1'b0 : mdone) | e[0];
        if (vld && code == CODE_LDMF) mmf = ac[5:3];
        mcmd = nc;
    endtask

    task automatic iot(input bit vld, input logic [11:0] code, input logic [11:0] ac,
                       input logic [4:0] e, input string tag);
        logic [11:0] x_ac;
        logic        x_clr, x_skip;
        @(negedge clk);
        iot_valid = vld; iot_code = code; ac_in = ac; ev = e;
        #1;
        x_ac   = !vld ? 12'o0 : (code == CODE_RDA) ? {mcmd, 2'b00} :
                 (code == CODE_RDB) ? exp_b() : 12'o0;
        x_clr  = vld && (code == CODE_LDA || code == CODE_LDMF);
        x_skip = vld && code == CODE_SKIP && ((|merr) | mdone);
        chk(ac_out == x_ac, {tag, " ac_out"}, ac_out, x_ac);
        chk(ac_clear == x_clr, {tag, " ac_clear"}, {11'b0, ac_clear}, {11'b0, x_clr});
        chk(skip == x_skip, {tag, " skip"}, {11'b0, skip}, {11'b0, x_skip});
        @(posedge clk);
        #1;
        model_step(vld, code, ac, e);
        iot_valid = 1'b0; ev = '0;
        check_static(tag);
    endtask

    task automatic rd_a(); iot(1'b1, CODE_RDA, 12'o0, 5'b0, "R5 readA"); endtask
    task automatic rd_b(); iot(1'b1, CODE_RDB, 12'o0, 5'b0, "R6 readB"); endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        check_static("R1");
        rd_a();
        rd_b();

        // R2 / R9 / R12 / R11: XOR sweep over every 10-bit load pattern, flags kept
        for (int i = 0; i < 1024; i++) begin
            iot(1'b1, CODE_LDA, {i[9:0], 2'b11}, 5'b0, "R2 load");
            rd_a();
            if (i % 64 == 0) rd_b();   // R9 select error visibility
        end

        // R4: clear command word, flags kept
        iot(1'b1, CODE_LDA, 12'o5252, 5'b0, "R2 setup");
        iot(1'b1, CODE_CLRA, 12'o7777, 5'b0, "R4 clrA");
        rd_a();
        rd_b();

        // R10 / R3 / R8 / R11: every event combination crossed with every keep/clear setting
        iot(1'b1, CODE_LDA, 12'o0004, 5'b0, "R11 enable");   // command bit 9 on
        for (int m = 0; m < 32; m++) begin
            for (int k = 0; k < 4; k++) begin
                iot(1'b1, CODE_LDA, 12'o0000, 5'b0, "R3 clear");
                iot(1'b1, CODE_SKIP, 12'o0, 5'b0, "R8 skip none");
                @(negedge clk); ev = m[4:0];
                @(posedge clk); #1; model_step(1'b0, 12'o0, 12'o0, m[4:0]); ev = '0;
                check_static("R10 event");
                rd_b();
                iot(1'b1, CODE_SKIP, 12'o0, 5'b0, "R8 skip");
                iot(1'b1, CODE_LDA, {10'b0, k[1:0]}, 5'b0, "R3 keep");
                rd_b();
                // event arriving with a clearing load wins
                iot(1'b1, CODE_LDA, 12'o0000, m[4:0], "R10 race");
                rd_b();
            end
        end

        // R7: memory field sweep with errors held
        @(negedge clk); ev = 5'b10000;
        @(posedge clk); #1; model_step(1'b0, 12'o0, 12'o0, 5'b10000); ev = '0;
        for (int v = 0; v < 8; v++) begin
            iot(1'b1, CODE_LDMF, {6'o52, v[2:0], 3'o5}, 5'b0, "R7 ldmf");
            rd_b();
        end

        // R13: unused codes in the group, and a load with the strobe low
        iot(1'b1, CODE_LDA, 12'o1233, 5'b0, "R2 setup");
        for (int c = 12'o6760; c <= 12'o6777; c++) begin
            if (c == CODE_RDA || c == CODE_CLRA || c == CODE_LDA ||
                c == CODE_SKIP || c == CODE_RDB || c == CODE_LDMF) continue;
            iot(1'b1, c[11:0], 12'o7777, 5'b0, "R13 unused");
            rd_a();
            rd_b();
        end
        iot(1'b0, CODE_LDA, 12'o7770, 5'b0, "R13 novalid");
        iot(1'b0, CODE_CLRA, 12'o0, 5'b0, "R13 novalid");
        rd_a();
        rd_b();

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5 * 190000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule